// File: doc/BRIEF.md
# Cascadable Dual 8-bit Timer Pair

This block holds two 8-bit up-counters, a high channel and a low channel, each with two compare registers (A and B), a control register selecting its count source and its clear condition, and a status register holding sticky overflow, compare-A and compare-B flags. A shared count tick `tick_i` comes from an external prescaler. The two channels can run apart, or be joined into one 16-bit counter with the low channel as the lower byte. They can also be chained so that the low channel counts the high channel's compare-A events. A capture input with a selectable edge loads the current count into the compare-B registers.

Operating mode is held by a small state machine with four states. In SPLIT the channels run independently. WIDE is the 16-bit counter, entered when the high channel's source field is 3'b100. CHAIN is the event chain, entered when the low channel's source field is 3'b100. STALL is entered when both fields are 3'b100. Every state moves to the state its target decode names, so every state-to-state transition exists (for example SPLIT->WIDE, WIDE->STALL, STALL->CHAIN, CHAIN->SPLIT). The state is updated one clock after the control registers, so a control write takes effect on the second rising edge after it.

Register writes use `wr_en`, `wr_addr` and `wr_data`. The addresses are: 0 high control, 1 low control, 2 high status, 3 low status, 4 high count, 5 low count, 6 high compare A, 7 low compare A, 8 high compare B, 9 low compare B. In a control byte, bits [2:0] are the source (000 stopped, 001 `tick_i`, 100 link) and bits [4:3] are the clear select (00 none, 01 clear on A, 10 clear on B, 11 none). In a status byte, bits [2:0] are the flags (bit0 overflow, bit1 compare A, bit2 compare B). In the high status byte only, bits [4:3] are the capture edge and bit 5 is capture enable.

Top module: `tmr_pair`

## Requirements
- R1: After reset both counts are 0, all four compare registers are 0xFF, all flags are 0 and both sources are stopped.
- R2: In SPLIT a channel with source 001 adds one per cycle with `tick_i` high. With source 000 it holds.
- R3: A compare event happens when a tick moves the count onto a compare value, and it sets that compare flag. With clear select 01 (or 10), a tick while the count equals compare A (or B) loads 0, so the count runs 0..N.
- R4: In SPLIT a tick from 0xFF gives 0x00 and sets the channel's overflow flag.
- R5: In WIDE the low channel's source drives a 16-bit count {high,low}. The low byte carry adds to the high byte on the same edge, and high-channel compares use {high reg, low reg}.
- R6: In WIDE the high overflow flag sets only on a 16-bit wrap 0xFFFF->0x0000. The low overflow flag sets on every low-byte wrap 0xFF->0x00.
- R7: In WIDE only the high clear select acts, and it clears both bytes at once. The low clear select is ignored.
- R8: In CHAIN the low count adds one per high compare-A event and does not count ticks.
- R9: In STALL neither count moves.
- R10: The mode follows a control write one cycle late. A tick on the edge right after the write still uses the old mode.
- R11: With capture enable set, the input is passed through two flops. The edge select is 01 rising, 10 falling, 11 both and 00 none. On the chosen edge the count is loaded into compare B and the compare-B flag sets. With capture enabled, compare B takes part in no matching or clearing.
- R12: A capture in WIDE loads the high and low bytes into the two compare-B registers and sets the compare-B flag in both status registers.
- R13: Flags stay set until a status write puts 0 in their bit. Writing 1 leaves a flag alone, and a flag event on the same edge as a clearing write leaves the flag set.
- R14: Writes go to the register named by the address map. A count write wins over a tick on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tick_i | input | 1 | Count tick from the prescaler |
| cap_i | input | 1 | Asynchronous capture input |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | CW | Write data |
| hi_cnt_o | output | CW | High channel count |
| lo_cnt_o | output | CW | Low channel count |
| hi_cmb_o | output | CW | High compare-B / capture register |
| lo_cmb_o | output | CW | Low compare-B / capture register |
| hi_flags_o | output | 3 | High flags {B, A, overflow} |
| lo_flags_o | output | 3 | Low flags {B, A, overflow} |
| hi_mata_o | output | 1 | High compare-A event pulse, one cycle late |
| hi_matb_o | output | 1 | High compare-B event pulse, one cycle late |
| lo_mata_o | output | 1 | Low compare-A event pulse, one cycle late |
| lo_matb_o | output | 1 | Low compare-B event pulse, one cycle late |

## Verification
Some rules are checked by the assertions on every cycle. Counts freeze in STALL, and in CHAIN the low count moves only on a high compare-A event. A 16-bit clear zeroes both bytes. Flags stay set with no clearing write, STALL is entered whenever both link codes are present, and a capture loads the count and sets its flag. Other rules can only be shown by the bench's scenarios: the exact count after a run of ticks, when the overflow flags fire at byte and word boundaries, the one-cycle mode latency, edge-select filtering through the synchronizer, and set-over-clear priority.

// File: rtl/tmr_pair_pkg.sv
package tmr_pair_pkg;
    typedef enum logic [1:0] {
        MODE_SPLIT = 2'd0,
        MODE_WIDE  = 2'd1,
        MODE_CHAIN = 2'd2,
        MODE_STALL = 2'd3
    } mode_e;

    localparam logic [2:0] SRC_OFF  = 3'b000;
    localparam logic [2:0] SRC_TICK = 3'b001;
    localparam logic [2:0] SRC_LINK = 3'b100;

    localparam logic [1:0] CLR_ON_A = 2'b01;
    localparam logic [1:0] CLR_ON_B = 2'b10;

    localparam logic [3:0] AD_HI_CTL = 4'd0;
    localparam logic [3:0] AD_LO_CTL = 4'd1;
    localparam logic [3:0] AD_HI_STS = 4'd2;
    localparam logic [3:0] AD_LO_STS = 4'd3;
    localparam logic [3:0] AD_HI_CNT = 4'd4;
    localparam logic [3:0] AD_LO_CNT = 4'd5;
    localparam logic [3:0] AD_HI_CMA = 4'd6;
    localparam logic [3:0] AD_LO_CMA = 4'd7;
    localparam logic [3:0] AD_HI_CMB = 4'd8;
    localparam logic [3:0] AD_LO_CMB = 4'd9;

    typedef struct packed {
        logic cmfb;
        logic cmfa;
        logic ovf;
    } flags_t;
endpackage

// File: rtl/tmr_mode_fsm.sv
module tmr_mode_fsm
    import tmr_pair_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] hi_src,
    input  logic [2:0] lo_src,
    output mode_e      mode_o
);
    logic  hi_link;
    logic  lo_link;
    mode_e state_q;
    mode_e state_d;
    mode_e target;

    assign hi_link = (hi_src == SRC_LINK);
    assign lo_link = (lo_src == SRC_LINK);

    always_comb begin
        if (hi_link && lo_link)  target = MODE_STALL;
        else if (hi_link)        target = MODE_WIDE;
        else if (lo_link)        target = MODE_CHAIN;
        else                     target = MODE_SPLIT;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_SPLIT: if (target != MODE_SPLIT) state_d = target;
            MODE_WIDE:  if (target != MODE_WIDE)  state_d = target;
            MODE_CHAIN: if (target != MODE_CHAIN) state_d = target;
            MODE_STALL: if (target != MODE_STALL) state_d = target;
            default:    state_d = MODE_SPLIT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MODE_SPLIT;
        else        state_q <= state_d;
    end

    assign mode_o = state_q;

    // R9
    stall_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_link && lo_link) |=> (state_q == MODE_STALL));
endmodule

// File: rtl/tmr_capture.sv
module tmr_capture (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cap_i,
    input  logic       cfg_we,
    input  logic [2:0] cfg_d,
    output logic       ice_o,
    output logic       evt_o
);
    logic       s1_q, s2_q, s3_q;
    logic [1:0] edge_q;
    logic       ice_q;
    logic       rise, fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= 1'b0;
            s2_q <= 1'b0;
            s3_q <= 1'b0;
        end else begin
            s1_q <= cap_i;
            s2_q <= s1_q;
            s3_q <= s2_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            edge_q <= 2'b00;
            ice_q  <= 1'b0;
        end else if (cfg_we) begin
            edge_q <= cfg_d[1:0];
            ice_q  <= cfg_d[2];
        end
    end

    assign rise  = s2_q & ~s3_q;
    assign fall  = ~s2_q & s3_q;
    assign ice_o = ice_q;

    always_comb begin
        unique case (edge_q)
            2'b01:   evt_o = ice_q & rise;
            2'b10:   evt_o = ice_q & fall;
            2'b11:   evt_o = ice_q & (rise | fall);
            default: evt_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
    import tmr_pair_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_ctl,
    input  logic          wr_sts,
    input  logic          wr_cnt,
    input  logic          wr_cma,
    input  logic          wr_cmb,
    input  logic [CW-1:0] wr_data,
    input  logic          step,
    input  logic [CW-1:0] nxt,
    input  logic          evt_ovf,
    input  logic          evt_a,
    input  logic          evt_b,
    input  logic          cap_ld,
    input  logic [CW-1:0] cap_val,
    output logic [CW-1:0] cnt,
    output logic [CW-1:0] cma,
    output logic [CW-1:0] cmb,
    output logic [2:0]    src,
    output logic [1:0]    clr_sel,
    output flags_t        flags,
    output logic          mat_a,
    output logic          mat_b
);
    flags_t set_v;
    flags_t keep_v;

    assign set_v  = '{cmfb: evt_b | cap_ld, cmfa: evt_a, ovf: evt_ovf};
    assign keep_v = wr_sts ? flags_t'(wr_data[2:0]) : 3'b111;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            cma     <= '1;
            cmb     <= '1;
            src     <= SRC_OFF;
            clr_sel <= 2'b00;
            flags   <= '0;
            mat_a   <= 1'b0;
            mat_b   <= 1'b0;
        end else begin
            if (wr_cnt)    cnt <= wr_data;
            else if (step) cnt <= nxt;
            if (wr_cma)    cma <= wr_data;
            if (cap_ld)      cmb <= cap_val;
            else if (wr_cmb) cmb <= wr_data;
            if (wr_ctl) begin
                src     <= wr_data[2:0];
                clr_sel <= wr_data[4:3];
            end
            flags <= set_v | (flags & keep_v);
            mat_a <= evt_a;
            mat_b <= evt_b;
        end
    end

    // R13
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags != 3'b000) && !wr_sts) |=> ((flags & $past(flags)) == $past(flags)));
endmodule

// File: rtl/tmr_pair.sv
module tmr_pair
    import tmr_pair_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic          cap_i,
    input  logic          wr_en,
    input  logic [3:0]    wr_addr,
    input  logic [CW-1:0] wr_data,
    output logic [CW-1:0] hi_cnt_o,
    output logic [CW-1:0] lo_cnt_o,
    output logic [CW-1:0] hi_cmb_o,
    output logic [CW-1:0] lo_cmb_o,
    output logic [2:0]    hi_flags_o,
    output logic [2:0]    lo_flags_o,
    output logic          hi_mata_o,
    output logic          hi_matb_o,
    output logic          lo_mata_o,
    output logic          lo_matb_o
);
    localparam int WW = 2 * CW;

    mode_e         mode;
    logic [CW-1:0] hi_cnt, lo_cnt, hi_cma, lo_cma, hi_cmb, lo_cmb;
    logic [2:0]    hi_src, lo_src;
    logic [1:0]    hi_clr_sel, lo_clr_sel;
    flags_t        hi_flags, lo_flags;
    logic          ice, cap_evt;
    logic          hi_own, lo_own;

    // per-channel write decode
    logic [1:0] wctl, wsts, wcnt, wcma, wcmb;
    assign wctl = {wr_en && wr_addr == AD_HI_CTL, wr_en && wr_addr == AD_LO_CTL};
    assign wsts = {wr_en && wr_addr == AD_HI_STS, wr_en && wr_addr == AD_LO_STS};
    assign wcnt = {wr_en && wr_addr == AD_HI_CNT, wr_en && wr_addr == AD_LO_CNT};
    assign wcma = {wr_en && wr_addr == AD_HI_CMA, wr_en && wr_addr == AD_LO_CMA};
    assign wcmb = {wr_en && wr_addr == AD_HI_CMB, wr_en && wr_addr == AD_LO_CMB};

    assign hi_own = tick_i && (hi_src == SRC_TICK);
    assign lo_own = tick_i && (lo_src == SRC_TICK);

    // split-mode per-byte next values
    logic          h_clr, l_clr;
    logic [CW-1:0] h_next, l_next;
    assign h_clr  = ((hi_clr_sel == CLR_ON_A) && (hi_cnt == hi_cma)) ||
                    ((hi_clr_sel == CLR_ON_B) && !ice && (hi_cnt == hi_cmb));
    assign l_clr  = ((lo_clr_sel == CLR_ON_A) && (lo_cnt == lo_cma)) ||
                    ((lo_clr_sel == CLR_ON_B) && (lo_cnt == lo_cmb));
    assign h_next = h_clr ? '0 : hi_cnt + 1'b1;
    assign l_next = l_clr ? '0 : lo_cnt + 1'b1;

    // joined 16-bit datapath
    logic [WW-1:0] w_cnt, w_cma, w_cmb, w_next;
    logic          w_clr;
    assign w_cnt  = {hi_cnt, lo_cnt};
    assign w_cma  = {hi_cma, lo_cma};
    assign w_cmb  = {hi_cmb, lo_cmb};
    assign w_clr  = ((hi_clr_sel == CLR_ON_A) && (w_cnt == w_cma)) ||
                    ((hi_clr_sel == CLR_ON_B) && !ice && (w_cnt == w_cmb));
    assign w_next = w_clr ? '0 : w_cnt + 1'b1;

    // high channel split-mode events, reused by the chain
    logic sp_h_ovf, sp_h_a, sp_h_b;
    assign sp_h_ovf = hi_own && !h_clr && (&hi_cnt);
    assign sp_h_a   = hi_own && (h_next == hi_cma);
    assign sp_h_b   = hi_own && !ice && (h_next == hi_cmb);

    logic          hi_step, lo_step;
    logic [CW-1:0] hi_nx, lo_nx;
    logic          hi_ovf, hi_a, hi_b, lo_ovf, lo_a, lo_b;

    always_comb begin
        hi_step = 1'b0; hi_nx = h_next; hi_ovf = 1'b0; hi_a = 1'b0; hi_b = 1'b0;
        lo_step = 1'b0; lo_nx = l_next; lo_ovf = 1'b0; lo_a = 1'b0; lo_b = 1'b0;
        unique case (mode)
            MODE_SPLIT: begin
                hi_step = hi_own; hi_ovf = sp_h_ovf; hi_a = sp_h_a; hi_b = sp_h_b;
                lo_step = lo_own;
                lo_ovf  = lo_own && !l_clr && (&lo_cnt);
                lo_a    = lo_own && (l_next == lo_cma);
                lo_b    = lo_own && (l_next == lo_cmb);
            end
            MODE_CHAIN: begin
                hi_step = hi_own; hi_ovf = sp_h_ovf; hi_a = sp_h_a; hi_b = sp_h_b;
                lo_step = sp_h_a;
                lo_ovf  = sp_h_a && !l_clr && (&lo_cnt);
                lo_a    = sp_h_a && (l_next == lo_cma);
                lo_b    = sp_h_a && (l_next == lo_cmb);
            end
            MODE_WIDE: begin
                lo_step = lo_own;
                lo_nx   = w_next[CW-1:0];
                hi_step = lo_own && (w_clr || (&lo_cnt));
                hi_nx   = w_next[WW-1:CW];
                hi_ovf  = lo_own && !w_clr && (&w_cnt);
                hi_a    = lo_own && (w_next == w_cma);
                hi_b    = lo_own && !ice && (w_next == w_cmb);
                lo_ovf  = lo_own && !w_clr && (&lo_cnt);
                lo_a    = lo_own && (w_next[CW-1:0] == lo_cma);
                lo_b    = lo_own && !ice && (w_next[CW-1:0] == lo_cmb);
            end
            MODE_STALL: ;
            default: ;
        endcase
    end

    logic lo_cap;
    assign lo_cap = cap_evt && (mode == MODE_WIDE);

    tmr_mode_fsm u_mode (
        .clk    (clk),
        .rst_n  (rst_n),
        .hi_src (hi_src),
        .lo_src (lo_src),
        .mode_o (mode)
    );

    tmr_capture u_cap (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap_i  (cap_i),
        .cfg_we (wsts[1]),
        .cfg_d  (wr_data[5:3]),
        .ice_o  (ice),
        .evt_o  (cap_evt)
    );

    tmr_chan #(.CW(CW)) u_hi (
        .clk (clk), .rst_n (rst_n),
        .wr_ctl (wctl[1]), .wr_sts (wsts[1]), .wr_cnt (wcnt[1]),
        .wr_cma (wcma[1]), .wr_cmb (wcmb[1]), .wr_data (wr_data),
        .step (hi_step), .nxt (hi_nx),
        .evt_ovf (hi_ovf), .evt_a (hi_a), .evt_b (hi_b),
        .cap_ld (cap_evt), .cap_val (hi_cnt),
        .cnt (hi_cnt), .cma (hi_cma), .cmb (hi_cmb),
        .src (hi_src), .clr_sel (hi_clr_sel), .flags (hi_flags),
        .mat_a (hi_mata_o), .mat_b (hi_matb_o)
    );

    tmr_chan #(.CW(CW)) u_lo (
        .clk (clk), .rst_n (rst_n),
        .wr_ctl (wctl[0]), .wr_sts (wsts[0]), .wr_cnt (wcnt[0]),
        .wr_cma (wcma[0]), .wr_cmb (wcmb[0]), .wr_data (wr_data),
        .step (lo_step), .nxt (lo_nx),
        .evt_ovf (lo_ovf), .evt_a (lo_a), .evt_b (lo_b),
        .cap_ld (lo_cap), .cap_val (lo_cnt),
        .cnt (lo_cnt), .cma (lo_cma), .cmb (lo_cmb),
        .src (lo_src), .clr_sel (lo_clr_sel), .flags (lo_flags),
        .mat_a (lo_mata_o), .mat_b (lo_matb_o)
    );

    assign hi_cnt_o   = hi_cnt;
    assign lo_cnt_o   = lo_cnt;
    assign hi_cmb_o   = hi_cmb;
    assign lo_cmb_o   = lo_cmb;
    assign hi_flags_o = hi_flags;
    assign lo_flags_o = lo_flags;

    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_STALL && !wr_en) |=> ($stable(hi_cnt) && $stable(lo_cnt)));

    // R7
    wide_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_WIDE && lo_own && w_clr && !wr_en) |=> (hi_cnt == '0 && lo_cnt == '0));

    // R8
    chain_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_CHAIN && !sp_h_a && !wr_en) |=> $stable(lo_cnt));

    // R11
    capture_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt |=> (hi_flags.cmfb && hi_cmb == $past(hi_cnt)));
endmodule

// File: tb/tmr_pair_tb.sv
`timescale 1ns/1ps
module tmr_pair_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       cap = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_addr = 4'd0;
    logic [7:0] wr_data = 8'd0;
    logic [7:0] hi_cnt, lo_cnt, hi_cmb, lo_cmb;
    logic [2:0] hi_fl, lo_fl;
    logic       hma, hmb, lma, lmb;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    tmr_pair #(.CW(8)) dut_i (
        .clk (clk), .rst_n (rst_n), .tick_i (tick), .cap_i (cap),
        .wr_en (wr_en), .wr_addr (wr_addr), .wr_data (wr_data),
        .hi_cnt_o (hi_cnt), .lo_cnt_o (lo_cnt), .hi_cmb_o (hi_cmb), .lo_cmb_o (lo_cmb),
        .hi_flags_o (hi_fl), .lo_flags_o (lo_fl),
        .hi_mata_o (hma), .hi_matb_o (hmb), .lo_mata_o (lma), .lo_matb_o (lmb)
    );

    localparam logic [3:0] HCTL = 0, LCTL = 1, HSTS = 2, LSTS = 3, HCNT = 4,
                           LCNT = 5, HCMA = 6, LCMA = 7, HCMB = 8, LCMB = 9;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic run(input int n);
        if (n > 0) begin
            @(negedge clk); tick = 1'b1;
            repeat (n) @(negedge clk);
            tick = 1'b0;
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int exp_split(input int k, input int cor);
        return k % (cor + 1);
    endfunction

    function automatic int exp_wide(input int start, input int k);
        return (start + k) & 16'hFFFF;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual hung expected finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        chk("R1 hi_cnt", hi_cnt, 0);
        chk("R1 lo_cnt", lo_cnt, 0);
        chk("R1 hi_cmb", hi_cmb, 8'hFF);
        chk("R1 lo_cmb", lo_cmb, 8'hFF);
        chk("R1 flags", {hi_fl, lo_fl}, 0);

        // R14 R2 count write then ticks, then stopped
        wr(HCNT, 8'h10); wr(HCTL, 8'h01); idle(1);
        run(5);
        chk("R2 R14 count", hi_cnt, 8'h15);
        wr(HCTL, 8'h00); run(3);
        chk("R2 hold", hi_cnt, 8'h15);

        // R3 clear on A
        wr(HCMA, 8'd4); wr(HCNT, 0); wr(HSTS, 0); wr(HCTL, 8'h09); idle(1);
        run(7);
        chk("R3 clr A count", hi_cnt, 2);
        chk("R3 cmfa", hi_fl[1], 1);
        // R3 clear on B
        wr(HCTL, 8'h00); wr(HCMB, 8'd2); wr(HCNT, 0); wr(HSTS, 0); wr(HCTL, 8'h11); idle(1);
        run(4);
        chk("R3 clr B count", hi_cnt, 1);
        chk("R3 cmfb", hi_fl[2], 1);
        wr(HCTL, 8'h00); wr(HCMB, 8'hFF);

        // R4 overflow
        wr(HCNT, 8'hFE); wr(HSTS, 0); wr(HCTL, 8'h01); idle(1);
        run(2);
        chk("R4 wrap", hi_cnt, 0);
        chk("R4 ovf", hi_fl[0], 1);

        // R13 sticky, write 1 no effect, set wins over clear
        wr(HCMA, 8'h50); wr(HCNT, 8'h4F); wr(HSTS, 0);
        @(negedge clk); wr_en = 1'b1; wr_addr = HSTS; wr_data = 8'h00; tick = 1'b1;
        @(negedge clk); wr_en = 1'b0; tick = 1'b0;
        chk("R13 set wins", hi_fl[1], 1);
        wr(HCTL, 8'h00); wr(HSTS, 8'h02);
        chk("R13 write one keeps", hi_fl[1], 1);
        wr(HSTS, 8'h00);
        chk("R13 write zero clears", hi_fl[1], 0);

        // R3 random split runs
        for (int i = 0; i < 20; i++) begin
            int cor;
            int k;
            cor = $urandom_range(1, 200);
            k   = $urandom_range(0, 300);
            wr(HCTL, 8'h00); wr(HSTS, 0); wr(HCNT, 0); wr(HCMA, cor[7:0]);
            wr(HCTL, 8'h09); idle(1);
            run(k);
            chk("R3 rand count", hi_cnt, exp_split(k, cor));
            chk("R3 rand cmfa", hi_fl[1], (k >= cor) ? 1 : 0);
        end

        // R5 R6 joined counter
        wr(HCTL, 8'h00); wr(HCMA, 8'hFF);
        wr(HCTL, 8'h04); wr(LCTL, 8'h01); idle(1);
        wr(HCNT, 8'h12); wr(LCNT, 8'hFE); wr(HSTS, 0); wr(LSTS, 0);
        run(3);
        chk("R5 carry", {hi_cnt, lo_cnt}, 16'h1301);
        chk("R6 lo ovf", lo_fl[0], 1);
        chk("R6 hi no ovf", hi_fl[0], 0);
        for (int i = 0; i < 12; i++) begin
            int st;
            int k;
            st = $urandom_range(0, 65535);
            k  = $urandom_range(0, 600);
            wr(HCNT, st[15:8]); wr(LCNT, st[7:0]); wr(HSTS, 0); wr(LSTS, 0);
            run(k);
            chk("R5 rand count", {hi_cnt, lo_cnt}, exp_wide(st, k));
            chk("R6 rand hi ovf", hi_fl[0], (st + k > 65535) ? 1 : 0);
            chk("R6 rand lo ovf", lo_fl[0], ((st & 255) + k > 255) ? 1 : 0);
        end

        // R10 mode latency
        wr(HCTL, 8'h00); idle(1);
        wr(HCNT, 0); wr(LCNT, 8'hFF);
        wr(HCTL, 8'h04);
        tick = 1'b1; @(negedge clk); tick = 1'b0;
        chk("R10 old mode no carry", {hi_cnt, lo_cnt}, 16'h0000);
        wr(LCNT, 8'hFF); run(1);
        chk("R10 new mode carry", {hi_cnt, lo_cnt}, 16'h0100);

        // R7 joined clear, low clear select ignored
        wr(HCMA, 8'h01); wr(LCMA, 8'h03); wr(LCMB, 8'h02);
        wr(HCTL, 8'h0C); wr(LCTL, 8'h11); idle(1);
        wr(HCNT, 8'h01); wr(LCNT, 8'h00); wr(HSTS, 0);
        run(5);
        chk("R7 joined clear", {hi_cnt, lo_cnt}, 16'h0001);
        chk("R7 hi cmfa", hi_fl[1], 1);

        // R8 chain
        wr(HCMA, 8'd2); wr(HCTL, 8'h09); wr(LCTL, 8'h04); idle(1);
        wr(HCNT, 0); wr(LCNT, 0);
        run(9);
        chk("R8 low events", lo_cnt, 3);
        chk("R8 high wraps", hi_cnt, 0);

        // R9 stall
        wr(HCTL, 8'h04); idle(1);
        wr(HCNT, 8'd5); wr(LCNT, 8'd7);
        run(10);
        chk("R9 stall", {hi_cnt, lo_cnt}, 16'h0507);

        // R11 capture in split mode
        wr(HCTL, 8'h00); wr(LCTL, 8'h00); idle(1);
        wr(HCNT, 8'h40); wr(HSTS, 8'h28);
        cap = 1'b1; idle(5);
        chk("R11 rise capture", hi_cmb, 8'h40);
        chk("R11 rise cmfb", hi_fl[2], 1);
        wr(HCNT, 8'h41); wr(HSTS, 8'h28);
        cap = 1'b0; idle(5);
        chk("R11 fall ignored", hi_cmb, 8'h40);
        chk("R11 fall no flag", hi_fl[2], 0);
        wr(HSTS, 8'h30);
        cap = 1'b1; idle(5);
        chk("R11 rise ignored", hi_fl[2], 0);
        cap = 1'b0; idle(5);
        chk("R11 fall capture", hi_cmb, 8'h41);
        wr(HCNT, 8'h42); wr(HSTS, 8'h18);
        cap = 1'b1; idle(5);
        chk("R11 disabled", hi_cmb, 8'h41);
        chk("R11 disabled flag", hi_fl[2], 0);
        wr(HSTS, 8'h20); wr(HCMB, 8'h40); wr(HCNT, 8'h3E); wr(HCTL, 8'h11); idle(1);
        run(4);
        chk("R11 no B clear", hi_cnt, 8'h42);
        chk("R11 no B flag", hi_fl[2], 0);

        // R12 capture in joined mode
        wr(HCTL, 8'h04); wr(LCTL, 8'h00); idle(1);
        wr(HCNT, 8'h12); wr(LCNT, 8'h34); wr(HSTS, 8'h38); wr(LSTS, 0);
        cap = 1'b0; idle(5);
        chk("R12 hi cmb", hi_cmb, 8'h12);
        chk("R12 lo cmb", lo_cmb, 8'h34);
        chk("R12 both cmfb", {hi_fl[2], lo_fl[2]}, 2'b11);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule